// File: doc/BRIEF.md
# Privileged Instruction Permission Gate

This block sits beside the execute stage of a processor core and rules on two privileged instructions: wait-for-interrupt and the address-translation fence. The decoder presents one instruction kind per cycle together with the current privilege level and two trap-control bits from the status register. The block then produces exactly one outcome for that instruction. The outcome is a halt request, a single-cycle translation-cache flush pulse, or an illegal-instruction exception that carries a fixed cause code.

All outcomes are registered. They appear on the outputs on the clock edge after the edge that samples the instruction. While the halt request is high, the core is asleep. Any instruction presented during that time is dropped. A wake input, meaning an enabled interrupt is pending, releases the halt on the next clock.

Encodings used throughout: instruction kind 0 = none, 1 = wait, 2 = fence, 3 = none. Privilege 0 = user, 1 = supervisor, 2 = reserved, 3 = machine.

Top module: `priv_op_gate`

## Requirements
- R1: After reset, halt_req, flush_pulse and illegal_valid are low and illegal_cause is zero.
- R2: A wait (kind 1) at machine privilege (3) raises halt_req one clock later, whatever the value of trap_wait.
- R3: A wait at supervisor (1) or user (0) privilege raises halt_req one clock later when trap_wait is 0, and raises illegal_valid for one cycle when trap_wait is 1.
- R4: A fence (kind 2) at user privilege (0) raises illegal_valid for one cycle and no flush.
- R5: A fence at supervisor privilege (1) pulses flush_pulse one clock later when trap_vm is 0, and raises illegal_valid instead when trap_vm is 1.
- R6: A fence at machine privilege (3) pulses flush_pulse one clock later, whatever the value of trap_vm.
- R7: Any wait or fence presented at the reserved privilege code 2 raises illegal_valid.
- R8: flush_pulse is high for exactly one cycle per accepted fence. Two fences accepted on consecutive cycles give two consecutive high cycles.
- R9: Once high, halt_req stays high until wake is sampled high, and it is low on the clock after that sample.
- R10: While halt_req is high, presented instructions cause no flush and no exception. wake sampled while halt_req is low has no effect.
- R11: Each instruction yields at most one of halt, flush or exception. illegal_cause equals 2 while illegal_valid is high and is 0 otherwise.
- R12: Instruction kinds 0 and 3 produce no outcome at any privilege or trap-bit setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_kind | input | 2 | Decoded instruction kind (0 none, 1 wait, 2 fence, 3 none) |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 2 reserved, 3 machine) |
| trap_wait | input | 1 | Status bit: trap waits below machine level |
| trap_vm | input | 1 | Status bit: trap fences at supervisor level |
| wake | input | 1 | Pending enabled interrupt; releases the halt |
| halt_req | output | 1 | Core halt request, held until wake |
| flush_pulse | output | 1 | One-cycle translation-cache flush |
| illegal_valid | output | 1 | One-cycle illegal-instruction exception |
| illegal_cause | output | CAUSE_W | Exception cause code, 2 when valid |

## Verification
The bound checker watches several properties on every cycle. It confirms that only one outcome occurs per instruction and that the cause code always agrees with the exception flag. It confirms that a halt persists until wake and drops right after it. It also confirms that fences at user and machine level always resolve the same way, and that instructions arriving during a halt have no effect. The remaining behaviour depends on specific combinations of privilege and trap bits, and only the bench's scenarios can show it. This covers the full permission table and the reserved privilege code. It also covers back-to-back fences giving adjacent pulses, and a wake arriving while the core is not halted.

// File: rtl/priv_op_pkg.sv
package priv_op_pkg;
   typedef enum logic [1:0] {
      OPK_NONE  = 2'd0,
      OPK_WAIT  = 2'd1,
      OPK_FENCE = 2'd2,
      OPK_RSVD  = 2'd3
   } opk_e;

   typedef enum logic [1:0] {
      LVL_USER = 2'd0,
      LVL_SUP  = 2'd1,
      LVL_RSVD = 2'd2,
      LVL_MACH = 2'd3
   } lvl_e;

   typedef struct packed {
      logic halt;
      logic flush;
      logic trap;
   } verdict_t;
endpackage

// File: rtl/priv_op_decide.sv
module priv_op_decide
   import priv_op_pkg::*;
(
   input  logic [1:0] op_kind,
   input  logic [1:0] cur_priv,
   input  logic       trap_wait,
   input  logic       trap_vm,
   input  logic       accept,
   output verdict_t   verdict
);
   logic is_wait;
   logic is_fence;
   verdict_t raw;

   assign is_wait  = (op_kind == OPK_WAIT);
   assign is_fence = (op_kind == OPK_FENCE);

   always_comb begin
      raw = '0;
      unique case (cur_priv)
         LVL_MACH: begin
            raw.halt  = is_wait;
            raw.flush = is_fence;
         end
         LVL_SUP: begin
            raw.halt  = is_wait && !trap_wait;
            raw.flush = is_fence && !trap_vm;
            raw.trap  = (is_wait && trap_wait) || (is_fence && trap_vm);
         end
         LVL_USER: begin
            raw.halt  = is_wait && !trap_wait;
            raw.trap  = (is_wait && trap_wait) || is_fence;
         end
         default: begin
            raw.trap  = is_wait || is_fence;
         end
      endcase
   end

   assign verdict = accept ? raw : '0;
endmodule

// File: rtl/priv_op_halt_ctl.sv
module priv_op_halt_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_halt,
   input  logic wake,
   output logic halted
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted <= 1'b0;
      end else if (halted) begin
         if (wake) halted <= 1'b0;
      end else if (set_halt) begin
         halted <= 1'b1;
      end
   end
endmodule

// File: rtl/priv_op_event_regs.sv
module priv_op_event_regs #(
   parameter int CAUSE_W       = 4,
   parameter int ILLEGAL_CAUSE = 2,
   parameter bit HOLD_CAUSE_ZERO = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire_flush,
   input  logic               fire_trap,
   output logic               flush_q,
   output logic               trap_q,
   output logic [CAUSE_W-1:0] cause_q
);
   localparam logic [CAUSE_W-1:0] CAUSE_VAL = CAUSE_W'(ILLEGAL_CAUSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_q <= 1'b0;
         trap_q  <= 1'b0;
      end else begin
         flush_q <= fire_flush;
         trap_q  <= fire_trap;
      end
   end

   generate
      if (HOLD_CAUSE_ZERO) begin : g_gated_cause
         assign cause_q = trap_q ? CAUSE_VAL : '0;
      end else begin : g_const_cause
         assign cause_q = CAUSE_VAL;
      end
   endgenerate
endmodule

// File: rtl/priv_op_gate.sv
module priv_op_gate
   import priv_op_pkg::*;
#(
   parameter int CAUSE_W       = 4,
   parameter int ILLEGAL_CAUSE = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         op_kind,
   input  logic [1:0]         cur_priv,
   input  logic               trap_wait,
   input  logic               trap_vm,
   input  logic               wake,
   output logic               halt_req,
   output logic               flush_pulse,
   output logic               illegal_valid,
   output logic [CAUSE_W-1:0] illegal_cause
);
   generate
      if (CAUSE_W < 2 || ILLEGAL_CAUSE < 0 || ILLEGAL_CAUSE >= (1 << CAUSE_W)) begin : g_bad_param
         $error("priv_op_gate: ILLEGAL_CAUSE does not fit in CAUSE_W bits");
      end
   endgenerate

   verdict_t verdict;
   logic     accept;

   assign accept = !halt_req;

   priv_op_decide u_decide (
      .op_kind   (op_kind),
      .cur_priv  (cur_priv),
      .trap_wait (trap_wait),
      .trap_vm   (trap_vm),
      .accept    (accept),
      .verdict   (verdict)
   );

   priv_op_halt_ctl u_halt (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_halt (verdict.halt),
      .wake     (wake),
      .halted   (halt_req)
   );

   priv_op_event_regs #(
      .CAUSE_W         (CAUSE_W),
      .ILLEGAL_CAUSE   (ILLEGAL_CAUSE),
      .HOLD_CAUSE_ZERO (1'b1)
   ) u_events (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_flush (verdict.flush),
      .fire_trap  (verdict.trap),
      .flush_q    (flush_pulse),
      .trap_q     (illegal_valid),
      .cause_q    (illegal_cause)
   );
endmodule

// File: rtl/priv_op_gate_chk.sv
module priv_op_gate_chk
   import priv_op_pkg::*;
#(
   parameter int CAUSE_W       = 4,
   parameter int ILLEGAL_CAUSE = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         op_kind,
   input logic [1:0]         cur_priv,
   input logic               trap_wait,
   input logic               trap_vm,
   input logic               wake,
   input logic               halt_req,
   input logic               flush_pulse,
   input logic               illegal_valid,
   input logic [CAUSE_W-1:0] illegal_cause
);
   logic ctl_unused;
   assign ctl_unused = trap_wait ^ trap_vm;

   // R11: a single outcome per instruction
   a_r11_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({illegal_valid, flush_pulse, $rose(halt_req)}));

   // R11: cause code tracks the exception flag
   a_r11_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_cause == (illegal_valid ? CAUSE_W'(ILLEGAL_CAUSE) : '0));

   // R9: halt persists without wake
   a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req && !wake) |=> halt_req);

   // R9: halt drops after wake
   a_r9_halt_release: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req && wake) |=> !halt_req);

   // R4: user fence always traps
   a_r4_user_fence_traps: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_req && op_kind == OPK_FENCE && cur_priv == LVL_USER) |=> (illegal_valid && !flush_pulse));

   // R6: machine fence always flushes
   a_r6_mach_fence_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_req && op_kind == OPK_FENCE && cur_priv == LVL_MACH) |=> (flush_pulse && !illegal_valid));

   // R2: machine wait always halts
   a_r2_mach_wait_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_req && op_kind == OPK_WAIT && cur_priv == LVL_MACH) |=> halt_req);

   // R10: instructions during halt are dropped
   a_r10_halted_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |=> (!flush_pulse && !illegal_valid));

   // R8: a flush only follows a fence
   a_r8_flush_from_fence: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |-> $past(op_kind == OPK_FENCE));

   // R12: idle kinds yield nothing
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_req && (op_kind == OPK_NONE || op_kind == OPK_RSVD)) |=> (!flush_pulse && !illegal_valid && !halt_req));
endmodule

bind priv_op_gate priv_op_gate_chk #(
   .CAUSE_W       (CAUSE_W),
   .ILLEGAL_CAUSE (ILLEGAL_CAUSE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .op_kind       (op_kind),
   .cur_priv      (cur_priv),
   .trap_wait     (trap_wait),
   .trap_vm       (trap_vm),
   .wake          (wake),
   .halt_req      (halt_req),
   .flush_pulse   (flush_pulse),
   .illegal_valid (illegal_valid),
   .illegal_cause (illegal_cause)
);

// File: tb/priv_op_gate_tb.sv
`timescale 1ns/1ps
module priv_op_gate_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] op_kind = 2'd0;
   logic [1:0] cur_priv = 2'd0;
   logic       trap_wait = 1'b0;
   logic       trap_vm = 1'b0;
   logic       wake = 1'b0;
   logic       halt_req;
   logic       flush_pulse;
   logic       illegal_valid;
   logic [3:0] illegal_cause;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   priv_op_gate u_dut (
      .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .cur_priv(cur_priv),
      .trap_wait(trap_wait), .trap_vm(trap_vm), .wake(wake),
      .halt_req(halt_req), .flush_pulse(flush_pulse),
      .illegal_valid(illegal_valid), .illegal_cause(illegal_cause)
   );

   // {kind, priv, tw, tvm, exp_halt, exp_flush, exp_exc, req}
   localparam logic [12:0] VECS [0:15] = '{
      {2'd1, 2'd3, 1'b0, 1'b0, 3'b100, 4'd2},  // R2
      {2'd1, 2'd3, 1'b1, 1'b1, 3'b100, 4'd2},  // R2
      {2'd1, 2'd1, 1'b0, 1'b1, 3'b100, 4'd3},  // R3
      {2'd1, 2'd1, 1'b1, 1'b0, 3'b001, 4'd3},  // R3
      {2'd1, 2'd0, 1'b0, 1'b0, 3'b100, 4'd3},  // R3
      {2'd1, 2'd0, 1'b1, 1'b0, 3'b001, 4'd3},  // R3
      {2'd2, 2'd0, 1'b0, 1'b0, 3'b001, 4'd4},  // R4
      {2'd2, 2'd1, 1'b1, 1'b0, 3'b010, 4'd5},  // R5
      {2'd2, 2'd1, 1'b0, 1'b1, 3'b001, 4'd5},  // R5
      {2'd2, 2'd3, 1'b0, 1'b1, 3'b010, 4'd6},  // R6
      {2'd2, 2'd3, 1'b1, 1'b0, 3'b010, 4'd6},  // R6
      {2'd1, 2'd2, 1'b0, 1'b0, 3'b001, 4'd7},  // R7
      {2'd2, 2'd2, 1'b0, 1'b0, 3'b001, 4'd7},  // R7
      {2'd0, 2'd3, 1'b1, 1'b1, 3'b000, 4'd12}, // R12
      {2'd3, 2'd0, 1'b1, 1'b1, 3'b000, 4'd12}, // R12
      {2'd3, 2'd2, 1'b0, 1'b0, 3'b000, 4'd12}  // R12
   };

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_outs(input string tag, input int eh, input int ef, input int ee);
      check(tag, "halt_req", int'(halt_req), eh);
      check(tag, "flush_pulse", int'(flush_pulse), ef);
      check(tag, "illegal_valid", int'(illegal_valid), ee);
      check("R11", "illegal_cause", int'(illegal_cause), ee ? 2 : 0);
   endtask

   // present one instruction for one cycle; return 3 ns after the capturing edge
   task automatic issue(input logic [1:0] k, input logic [1:0] p, input logic tw, input logic tv);
      op_kind = k; cur_priv = p; trap_wait = tw; trap_vm = tv;
      @(posedge clk);
      #1 op_kind = 2'd0;
      #2;
   endtask

   task automatic tick();
      @(posedge clk);
      #3;
   endtask

   task automatic release_halt();
      wake = 1'b1;
      @(posedge clk);
      #1 wake = 1'b0;
      #2;
      check("R9", "halt after wake", int'(halt_req), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3;
      // R1: reset state
      check_outs("R1", 0, 0, 0);
      rst_n = 1'b1;
      tick();
      check_outs("R1", 0, 0, 0);

      // permission table
      for (int i = 0; i < 16; i++) begin
         logic [12:0] v;
         string tag;
         v = VECS[i];
         tag = $sformatf("R%0d", v[3:0]);
         issue(v[12:11], v[10:9], v[8], v[7]);
         check_outs(tag, int'(v[6]), int'(v[5]), int'(v[4]));
         if (halt_req) release_halt();
         tick();
         check(tag, "flush next cycle", int'(flush_pulse), 0);
         check(tag, "exception next cycle", int'(illegal_valid), 0);
      end

      // R8: back-to-back fences give adjacent single pulses
      op_kind = 2'd2; cur_priv = 2'd3; trap_vm = 1'b1;
      @(posedge clk);
      #1 cur_priv = 2'd1; trap_vm = 1'b0;
      #2 check("R8", "first pulse", int'(flush_pulse), 1);
      @(posedge clk);
      #1 op_kind = 2'd0;
      #2 check("R8", "second pulse", int'(flush_pulse), 1);
      tick();
      check("R8", "pulse ends", int'(flush_pulse), 0);

      // R9: halt holds across idle cycles
      issue(2'd1, 2'd3, 1'b0, 1'b0);
      for (int j = 0; j < 5; j++) begin
         tick();
         check("R9", "halt held", int'(halt_req), 1);
      end

      // R10: instructions during halt are dropped
      issue(2'd2, 2'd0, 1'b0, 1'b0);
      check("R10", "exception while halted", int'(illegal_valid), 0);
      issue(2'd2, 2'd3, 1'b0, 1'b0);
      check("R10", "flush while halted", int'(flush_pulse), 0);
      check("R10", "still halted", int'(halt_req), 1);
      release_halt();

      // R10: wake with no halt has no effect; a wait in the same cycle still halts
      wake = 1'b1;
      tick();
      check("R10", "wake when idle", int'(halt_req), 0);
      issue(2'd1, 2'd0, 1'b0, 1'b0);
      wake = 1'b0;
      check("R10", "wait alongside wake", int'(halt_req), 1);
      release_halt();

      // R11: exception directly after wake carries cause 2
      issue(2'd1, 2'd1, 1'b1, 1'b0);
      check_outs("R11", 0, 0, 1);
      tick();
      check_outs("R11", 0, 0, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule